// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block is the device side of the read path of a small-page NAND flash. A host writes a read command byte and three address bytes over an 8-bit bus, qualifying each write strobe with a command latch or address latch enable. The block then goes busy for a configurable number of clock cycles while it stages the addressed page, and signals this on an active-low ready/busy output. After that, each read strobe returns one byte and moves the column forward.

Each page has 528 bytes: a first half (columns 0 to 255), a second half (256 to 511) and a 16-byte spare area (512 to 527). The command byte picks the region the column pointer starts in. When the last column is read, the block moves to the next page and goes busy again. The column restarts at 0 in the main regions, or at 512 in the spare region. A rising chip enable during the busy interval or the read phase cancels the read.

The byte stream out is flow-controlled by the host. The output-enable is the valid flag and the read strobe is the ready flag. A byte moves only in a cycle where both are high. The host applies back-pressure by withholding the read strobe, and the pointer then holds. The array contents are a fixed function of page and column, so no memory has to be loaded.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, `rb_o` is 1 and `io_oe_o` is 0. The region defaults to first-half mode, so three address bytes sent without a preceding command read from column {0, first byte}.
- R2: Command 0x00 sets the column to {0, first address byte} and command 0x01 sets it to {1, first address byte}. Here the first address byte is the low 8 column bits and the leading bit is column bit 8.
- R3: Command 0x50 sets the start column to 512 plus bits [3:0] of the first address byte.
- R4: The second and third address bytes form the page number as {third, second}, taken modulo 2^PAGE_W. After the third address write, `rb_o` is 0 for exactly LATENCY cycles and then returns to 1.
- R5: A read strobe with `ce_n_i` low and `rb_o` high drives `io_o` with value (col[7:0] + page*29 + col[9:8]*101) mod 256 and advances the column by one. The column never exceeds 527.
- R6: A read at column 527 increments the page modulo 2^PAGE_W, restarts the column at 0 in the main regions or at 512 in the spare region, and starts a new busy interval of LATENCY cycles.
- R7: The spare region persists across later address sequences until command 0x00 or 0x01 is written.
- R8: If `ce_n_i` is high while busy or in the read phase, the block returns to standby. `rb_o` is 1 from the next cycle, and later read strobes return nothing until a new address sequence.
- R9: Read strobes while `rb_o` is 0 produce no output and leave the column unchanged.
- R10: `io_oe_o` is 1 only in a cycle where the block is ready in the read phase, `ce_n_i` is low and `re_i` is 1.
- R11: A command byte other than 0x00, 0x01 and 0x50 is ignored and leaves the region unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Marks a write as a command byte |
| ale_i | input | 1 | Marks a write as an address byte |
| we_i | input | 1 | Write strobe, one cycle per byte |
| re_i | input | 1 | Read strobe, one cycle per byte (ready) |
| io_i | input | 8 | Command or address byte |
| io_o | output | 8 | Data byte at the current column |
| io_oe_o | output | 1 | Data byte valid / bus drive enable |
| rb_o | output | 1 | Ready (1) or busy (0) |

## Verification
The assertions assume that a strobe cycle never raises the command latch and the address latch together. They also assume that write and read strobes do not fall in the same cycle, and that address bytes arrive only after a command or from standby. The bench drives each byte as a single-cycle strobe with exactly one latch enable raised. It inserts a chip-enable deassertion before it reuses address cycles out of the read phase, so the stimulus stays inside these assumptions.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam int COL_W      = 10;
  localparam int COL_LAST   = 527;
  localparam int SPARE_BASE = 512;
  localparam logic [7:0] CMD_LOW   = 8'h00;
  localparam logic [7:0] CMD_HIGH  = 8'h01;
  localparam logic [7:0] CMD_SPARE = 8'h50;

  typedef enum logic [1:0] {RG_LOW, RG_HIGH, RG_SPARE} region_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_BUSY, ST_READ} state_e;

  function automatic logic [7:0] cell_value(input logic [15:0] page, input logic [COL_W-1:0] col);
    logic [7:0] hi;
    hi = {6'b0, col[9:8]};
    return 8'(col[7:0] + 8'(page[7:0] * 8'd29) + 8'(hi * 8'd101));
  endfunction
endpackage

// File: rtl/nand_rd_busy.sv
module nand_rd_busy #(
  parameter int LATENCY = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LATENCY - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= RELOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && !abort |=> busy); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !abort && !done |=> busy); // R4
endmodule

// File: rtl/nand_rd_ptr.sv
module nand_rd_ptr import nand_rd_pkg::*; #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              col_ld,
  input  logic [COL_W-1:0]  col_val,
  input  logic              row_lo_ld,
  input  logic              row_hi_ld,
  input  logic [7:0]        bus,
  input  logic              step,
  input  logic              spare,
  output logic [COL_W-1:0]  col,
  output logic [PAGE_W-1:0] page,
  output logic              wrap
);
  logic [7:0] row_lo;

  assign wrap = step && (col == COL_W'(COL_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col    <= '0;
      page   <= '0;
      row_lo <= '0;
    end else begin
      if (col_ld)    col    <= col_val;
      if (row_lo_ld) row_lo <= bus;
      if (row_hi_ld) page   <= PAGE_W'({bus, row_lo});
      if (step) begin
        if (wrap) begin
          col  <= spare ? COL_W'(SPARE_BASE) : '0;
          page <= page + 1'b1;
        end else begin
          col  <= col + 1'b1;
        end
      end
    end
  end

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COL_W'(COL_LAST)); // R5
  AST_WRAP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !row_hi_ld |=> page == $past(page) + 1'b1); // R6
endmodule

// File: rtl/nand_rd_ctrl.sv
module nand_rd_ctrl import nand_rd_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we,
  input  logic             re,
  input  logic [7:0]       bus,
  input  logic             done,
  input  logic             wrap,
  output state_e           state,
  output region_e          region,
  output logic             col_ld,
  output logic [COL_W-1:0] col_val,
  output logic             row_lo_ld,
  output logic             row_hi_ld,
  output logic             start,
  output logic             cancel,
  output logic             step
);
  logic [1:0] idx;
  logic accept, cmd_ok, cmd_hit, addr_hit, live, drop;

  assign accept   = !ce_n && we;
  assign cmd_ok   = (bus == CMD_LOW) || (bus == CMD_HIGH) || (bus == CMD_SPARE);
  assign cmd_hit  = accept && cle && !ale && cmd_ok;
  assign addr_hit = accept && ale && !cle && (state == ST_IDLE || state == ST_ADDR);
  assign live     = (state == ST_BUSY) || (state == ST_READ);
  assign drop     = ce_n && live;
  assign cancel   = drop || cmd_hit;

  assign col_ld    = addr_hit && (idx == 2'd0);
  assign row_lo_ld = addr_hit && (idx == 2'd1);
  assign row_hi_ld = addr_hit && (idx == 2'd2);
  assign start     = row_hi_ld;
  assign step      = (state == ST_READ) && !ce_n && re && !we;

  always_comb begin
    unique case (region)
      RG_HIGH:  col_val = {2'b01, bus};
      RG_SPARE: col_val = COL_W'(SPARE_BASE) + COL_W'(bus[3:0]);
      default:  col_val = {2'b00, bus};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      region <= RG_LOW;
      idx    <= 2'd0;
    end else if (drop) begin
      state <= ST_IDLE;
      idx   <= 2'd0;
    end else if (cmd_hit) begin
      state <= ST_ADDR;
      idx   <= 2'd0;
      if (bus == CMD_HIGH)       region <= RG_HIGH;
      else if (bus == CMD_SPARE) region <= RG_SPARE;
      else                       region <= RG_LOW;
    end else if (addr_hit) begin
      if (idx == 2'd2) begin
        state <= ST_BUSY;
        idx   <= 2'd0;
      end else begin
        state <= ST_ADDR;
        idx   <= idx + 1'b1;
      end
    end else if (state == ST_BUSY && done) begin
      state <= ST_READ;
    end else if (wrap) begin
      state <= ST_BUSY;
    end
  end

  AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> state == ST_BUSY); // R4
  AST_BAD_CMD_KEEPS_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cle && !ale && !cmd_ok |=> $stable(region)); // R11
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader import nand_rd_pkg::*; #(
  parameter int PAGE_W  = 4,
  parameter int LATENCY = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [7:0] io_i,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  output logic       rb_o
);
  state_e            state;
  region_e           region;
  logic              col_ld, row_lo_ld, row_hi_ld, start, cancel, step;
  logic              busy, done, wrap;
  logic [COL_W-1:0]  col_val, col;
  logic [PAGE_W-1:0] page;

  nand_rd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n_i), .cle(cle_i), .ale(ale_i), .we(we_i),
    .re(re_i), .bus(io_i), .done(done), .wrap(wrap), .state(state), .region(region),
    .col_ld(col_ld), .col_val(col_val), .row_lo_ld(row_lo_ld), .row_hi_ld(row_hi_ld),
    .start(start), .cancel(cancel), .step(step)
  );

  nand_rd_ptr #(.PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .col_ld(col_ld), .col_val(col_val),
    .row_lo_ld(row_lo_ld), .row_hi_ld(row_hi_ld), .bus(io_i), .step(step),
    .spare(region == RG_SPARE), .col(col), .page(page), .wrap(wrap)
  );

  nand_rd_busy #(.LATENCY(LATENCY)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(start || wrap), .abort(cancel),
    .busy(busy), .done(done)
  );

  assign rb_o    = !busy;
  assign io_oe_o = step;
  assign io_o    = cell_value(16'(page), col);

  AST_NO_OE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_o |-> !io_oe_o); // R9
  AST_ABORT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_i && !rb_o |=> rb_o); // R8
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe_o && col == COL_W'(COL_LAST) |=> !rb_o); // R6
  AST_SPARE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    region == RG_SPARE && state == ST_READ |-> col >= COL_W'(SPARE_BASE)); // R7
  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe_o |-> !ce_n_i && re_i); // R10
endmodule

// File: tb/test_nand_page_reader.sv
`timescale 1ns/1ps
module test_nand_page_reader;
  localparam int PAGE_W = 4;
  localparam int NP     = 1 << PAGE_W;
  localparam int LAT    = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] io_in = 8'h00;
  logic [7:0] io_out;
  logic io_oe, rb;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nand_page_reader #(.PAGE_W(PAGE_W), .LATENCY(LAT)) i_nand_page_reader (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .cle_i(cle), .ale_i(ale), .we_i(we),
    .re_i(re), .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe), .rb_o(rb)
  );

  function automatic int exp_byte(int pg, int col);
    return (col % 256 + pg * 29 + (col / 256) * 101) % 256;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 standby, 1 addressing, 2 busy, 3 reading
  int m_st = 0, m_rg = 0, m_col = 0, m_pg = 0, m_ai = 0, m_bc = 0, m_lo = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rg = 0; m_col = 0; m_pg = 0; m_ai = 0; m_bc = 0;
    end else if (ce_n && (m_st == 2 || m_st == 3)) begin
      m_st = 0; m_ai = 0;
    end else if (!ce_n && we && cle && !ale && (io_in == 8'h00 || io_in == 8'h01 || io_in == 8'h50)) begin
      m_rg = (io_in == 8'h00) ? 0 : (io_in == 8'h01) ? 1 : 2;
      m_st = 1; m_ai = 0;
    end else if (!ce_n && we && ale && !cle && (m_st == 0 || m_st == 1)) begin
      m_st = 1;
      if (m_ai == 0) begin
        m_col = (m_rg == 2) ? 512 + (io_in % 16) : m_rg * 256 + io_in;
        m_ai = 1;
      end else if (m_ai == 1) begin
        m_lo = io_in; m_ai = 2;
      end else begin
        m_pg = (m_lo + io_in * 256) % NP; m_ai = 0; m_st = 2; m_bc = LAT;
      end
    end else if (m_st == 2) begin
      m_bc--;
      if (m_bc == 0) m_st = 3;
    end else if (m_st == 3 && !ce_n && re && !we) begin
      if (m_col == 527) begin
        m_col = (m_rg == 2) ? 512 : 0;
        m_pg = (m_pg + 1) % NP; m_st = 2; m_bc = LAT;
      end else m_col++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #5;
      check("R4 model rb", rb, (m_st == 2) ? 0 : 1);
      check("R10 model oe", io_oe, (m_st == 3 && !ce_n && re && !we) ? 1 : 0);
      if (io_oe) check("R5 model data", io_out, exp_byte(m_pg, m_col));
    end
  end

  task automatic send_cmd(input logic [7:0] b);
    ce_n = 1'b0; cle = 1'b1; we = 1'b1; io_in = b;
    @(negedge clk);
    cle = 1'b0; we = 1'b0;
  endtask

  task automatic send_addr(input logic [7:0] c, input logic [7:0] p0, input logic [7:0] p1);
    ce_n = 1'b0;
    ale = 1'b1; we = 1'b1;
    io_in = c;  @(negedge clk);
    io_in = p0; @(negedge clk);
    io_in = p1; @(negedge clk);
    ale = 1'b0; we = 1'b0;
  endtask

  task automatic wait_ready();
    while (!rb) @(negedge clk);
  endtask

  task automatic read_exp(string tag, int pg, int col);
    re = 1'b1;
    #5;
    check(tag, io_oe, 1);
    check(tag, io_out, exp_byte(pg, col));
    @(negedge clk);
    re = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #5;
    check("R1 reset rb", rb, 1);
    check("R1 reset oe", io_oe, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: default first-half region without a command
    send_addr(8'h05, 8'h03, 8'h00);
    wait_ready();
    for (int c = 5; c < 9; c++) read_exp("R1 default region", 3, c);

    // R2: second half, crossing into spare columns
    send_cmd(8'h01);
    send_addr(8'hFE, 8'h02, 8'h00);
    wait_ready();
    for (int c = 510; c < 513; c++) read_exp("R2 second half", 2, c);

    // R3: spare start offset, then R6 wrap inside spare
    send_cmd(8'h50);
    send_addr(8'h1D, 8'h01, 8'h00);
    wait_ready();
    for (int c = 525; c < 528; c++) read_exp("R3 spare start", 1, c);
    #5; check("R6 reload busy", rb, 0);
    @(negedge clk);
    wait_ready();
    read_exp("R6 spare wrap column", 2, 512);

    // R8: CE high during read phase aborts
    ce_n = 1'b1; @(negedge clk);
    #5; check("R8 standby rb", rb, 1);
    @(negedge clk);
    ce_n = 1'b0; re = 1'b1; #5;
    check("R8 no data after abort", io_oe, 0);
    @(negedge clk); re = 1'b0;

    // R11 + R7: unknown command ignored, spare persists
    send_cmd(8'h77);
    send_addr(8'h20, 8'h04, 8'h00);
    wait_ready();
    read_exp("R7 spare persists R11", 4, 512);
    ce_n = 1'b1; @(negedge clk);

    // R9: strobes while busy ignored; R5 long run; R6 page wrap
    send_cmd(8'h00);
    send_addr(8'hFF, 8'h0F, 8'h00);
    for (int k = 0; k < 3; k++) begin
      re = 1'b1; #5;
      check("R9 no output while busy", io_oe, 0);
      @(negedge clk); re = 1'b0;
    end
    wait_ready();
    read_exp("R9 column unchanged", 15, 255);
    for (int c = 256; c < 528; c++) read_exp("R5 sequential", 15, c);
    #5; check("R6 busy after last column", rb, 0);
    @(negedge clk);
    wait_ready();
    read_exp("R6 page wraps to 0 column 0", 0, 0);

    // R8: CE high while busy
    send_cmd(8'h01);
    send_addr(8'h00, 8'h05, 8'h00);
    #5; check("R8 busy before abort", rb, 0);
    @(negedge clk);
    ce_n = 1'b1; @(negedge clk);
    #5; check("R8 abort during busy", rb, 1);
    @(negedge clk);
    ce_n = 1'b0; re = 1'b1; #5;
    check("R10 no oe in standby", io_oe, 0);
    @(negedge clk); re = 1'b0;

    // R4: page high byte and busy length
    send_cmd(8'h00);
    send_addr(8'h10, 8'h02, 8'h01);
    n = 0;
    while (!rb) begin n++; @(negedge clk); end
    check("R4 busy length", n, LAT);
    read_exp("R4 page from two bytes", (2 + 256) % NP, 16);

    // R10: no oe with CE high during read
    ce_n = 1'b1; re = 1'b1; #5;
    check("R10 oe needs CE", io_oe, 0);
    @(negedge clk); re = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule